// File: doc/BRIEF.md
# SPI Slave Memory Port

This block lets an external SPI host read and write an on-chip byte memory and hand short commands to a local processor. The host frames each transaction with an active-low chip select. A multi-byte frame carries a 16-bit address (most significant bit first) and then a command byte whose top bit picks the direction. In the following byte slot the block returns a processor-supplied status byte. Data bytes come next, and the address steps up by one after each of them until chip select rises. A frame holding only one byte delivers a bare command to the processor.

When a valid frame ends, the command byte is copied into a register the processor can read, and an interrupt flag is raised. Two idle command codes suppress this step, one for reads and one for writes. A safe mode bit confines host writes to a 16-byte window so the host cannot corrupt the rest of memory. The processor holds four control bits: port enable, interrupt enable, safe mode and the interrupt flag.

The serial pins are synchronized into the system clock domain. Memory accesses leave the block as one-cycle strobes on a synchronous byte RAM port whose read data appears one cycle after the read strobe.

Top module: `spi_mem_port`

## Requirements
- R1: A frame carries address bits 15..0, then a command byte (bit 7 = 1 read, 0 write), then a status slot, then data; in a write frame every complete data byte is stored at the current address.
- R2: The byte returned in the fourth slot (frame bits 24..31) equals `status_i`; in a read frame, memory data is returned from bit 32 onward. `miso_o` changes after a falling serial clock edge and is stable at the next rising edge.
- R3: After each data byte the address increments by one, for reads and for writes alike, until chip select rises.
- R4: A frame of exactly 8 bits loads that byte into `cmd_o` and sets the interrupt flag, whatever the byte's value (0x00 and 0x80 included).
- R5: A frame of 24 or more bits, ending on a byte boundary, loads its command byte into `cmd_o` and sets the interrupt flag, unless R6 applies.
- R6: A read frame with command 0x80, or a write frame with command 0x00, leaves `cmd_o` and the interrupt flag unchanged; its data transfer still takes place.
- R7: A frame of exactly 16 bits, or a frame that ends partway through a byte, changes neither `cmd_o` nor the flag, and the incomplete final byte is never written.
- R8: While safe mode is set, memory write strobes appear only for addresses 0x0400 to 0x040F; command and flag updates are not affected.
- R9: Control register layout: bit 0 port enable, bit 1 interrupt enable, bit 2 safe mode, bit 3 interrupt flag. A write with bit 3 = 0 clears the flag, a write with bit 3 = 1 leaves it as it was, and a hardware set in the same cycle takes priority over the clear.
- R10: `irq_o` is high only when both the flag and the interrupt enable are set.
- R11: While port enable is 0, serial activity is ignored: no memory strobes, no command or flag change, and `miso_oe_o` stays low.
- R12: After reset all four control bits, `cmd_o` and `irq_o` are 0. `miso_oe_o` is high only while the port is enabled and chip select is low.
- R13: Every memory write or read is a single-cycle strobe, and a write strobe is never asserted in the same cycle as a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the serial data pin |
| status_i | input | 8 | Status byte returned in the fourth slot |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the read strobe |
| reg_we_i | input | 1 | Processor write strobe for the control bits |
| reg_wdata_i | input | 4 | Processor write data for the control bits |
| ctl_o | output | 4 | Control bits read back: flag, safe, interrupt enable, enable |
| cmd_o | output | 8 | Last accepted command byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that each serial clock half-period lasts several system clocks, that `mosi_i` is steady around rising serial edges, and that chip select changes only while the serial clock is low. Under these conditions each received byte produces at most one strobe, and a strobe can never coincide with a frame boundary. The bench host toggles the serial pins only on falling system edges, eight system clocks apart. It also holds the processor's control writes apart from frame ends, except where R9 explicitly checks priority.

// File: rtl/spi_port_pkg.sv
// Shared constants and types for the SPI slave memory port.
// Assumes a fixed protocol geometry: 16-bit address, byte-wide data.
package spi_port_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CTL_W  = 4;

    // Control bit positions as seen by the processor.
    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_SAFE = 2;
    localparam int CTL_FLAG = 3;

    // Idle command codes that suppress the end-of-frame update.
    localparam logic [BYTE_W-1:0] RD_IDLE = 8'h80;
    localparam logic [BYTE_W-1:0] WR_IDLE = 8'h00;

    typedef enum logic [2:0] {
        PH_ADR_H,
        PH_ADR_L,
        PH_CMD,
        PH_STAT,
        PH_DATA
    } phase_t;
endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer bank for asynchronous serial pins.
// Assumes inputs are level signals much slower than clk; RST_VAL gives idle levels.
module spi_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage resynchronization of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end
        assign q_o[i] = sync_q;
    end
endmodule

// File: rtl/spi_safe_gate.sv
// Decides whether a memory write may proceed under safe mode.
// Assumes the window is [BASE, BASE+SIZE); a power-of-two aligned window uses a mask compare.
module spi_safe_gate
    import spi_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 16'h0400,
    parameter int                SIZE = 16
) (
    input  logic              safe_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              allow_o
);
    localparam int LOG2 = $clog2(SIZE);
    logic hit;

    if ((SIZE == (1 << LOG2)) && ((int'(BASE) % SIZE) == 0)) begin : g_mask
        localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(SIZE - 1);
        assign hit = ((addr_i & MASK) == (BASE & MASK));
    end else begin : g_range
        localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE} + (ADDR_W+1)'(SIZE);
        assign hit = (addr_i >= BASE) && ({1'b0, addr_i} < LIMIT);
    end

    assign allow_o = !safe_i || hit;
endmodule

// File: rtl/spi_ctl_regs.sv
// Processor-side control bits, command register and interrupt output.
// Assumes done_i is a one-cycle pulse; a hardware set beats a processor clear.
module spi_ctl_regs
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [CTL_W-1:0]  reg_wdata_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] done_cmd_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              irq_o
);
    logic en_q, ie_q, safe_q, flag_q;
    logic [BYTE_W-1:0] cmd_q;

    // Control bit updates from the processor and from frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            safe_q <= 1'b0;
            flag_q <= 1'b0;
            cmd_q  <= '0;
        end else begin
            if (reg_we_i) begin
                en_q   <= reg_wdata_i[CTL_EN];
                ie_q   <= reg_wdata_i[CTL_IE];
                safe_q <= reg_wdata_i[CTL_SAFE];
                if (!reg_wdata_i[CTL_FLAG]) flag_q <= 1'b0;
            end
            if (done_i) begin
                flag_q <= 1'b1;
                cmd_q  <= done_cmd_i;
            end
        end
    end

    always_comb begin
        ctl_o           = '0;
        ctl_o[CTL_EN]   = en_q;
        ctl_o[CTL_IE]   = ie_q;
        ctl_o[CTL_SAFE] = safe_q;
        ctl_o[CTL_FLAG] = flag_q;
    end

    assign cmd_o = cmd_q;
    assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/spi_frame.sv
// Frame engine: edge detection, byte assembly, phase tracking, status and
// read-data shifting, address auto-increment and end-of-frame decisions.
// Assumes synchronized pins, a serial half-period of several clk cycles,
// and memory read data one cycle after mem_re_o.
module spi_frame
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] status_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              wr_req_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] done_cmd_o
);
    logic sclk_d, csn_d;
    logic rise, fall, cs_start, cs_end;
    phase_t phase_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] sh_q, hi_q, cmd_q, tx_q, rdbuf_q, wdata_q, done_cmd_q;
    logic [BYTE_W-1:0] byte_next;
    logic [ADDR_W-1:0] addr_q;
    logic miso_q, re_q, re_d, we_q, done_q;
    logic multi_end, idle_code;

    // Previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    assign rise      = en_i && !csn_s && sclk_s && !sclk_d;
    assign fall      = en_i && !csn_s && !sclk_s && sclk_d;
    assign cs_start  = en_i && !csn_s && csn_d;
    assign cs_end    = en_i && csn_s && !csn_d;
    assign byte_next = {sh_q[BYTE_W-2:0], mosi_s};
    assign idle_code = cmd_q[BYTE_W-1] ? (cmd_q == RD_IDLE) : (cmd_q == WR_IDLE);
    assign multi_end = (phase_q == PH_STAT || phase_q == PH_DATA) && (bit_q == 3'd0);

    // Read-data capture one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_d    <= 1'b0;
            rdbuf_q <= '0;
        end else begin
            re_d <= re_q;
            if (re_d) rdbuf_q <= mem_rdata_i;
        end
    end

    // Main frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_ADR_H;
            bit_q      <= '0;
            sh_q       <= '0;
            hi_q       <= '0;
            cmd_q      <= '0;
            tx_q       <= '0;
            miso_q     <= 1'b0;
            addr_q     <= '0;
            re_q       <= 1'b0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            done_q     <= 1'b0;
            done_cmd_q <= '0;
        end else begin
            re_q   <= 1'b0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
            if (we_q) addr_q <= addr_q + 1'b1;
            if (!en_i || cs_start) begin
                phase_q <= PH_ADR_H;
                bit_q   <= '0;
                tx_q    <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (rise) begin
                    bit_q <= bit_q + 3'd1;
                    sh_q  <= byte_next;
                    if (bit_q == 3'd7) begin
                        case (phase_q)
                            PH_ADR_H: begin
                                hi_q    <= byte_next;
                                phase_q <= PH_ADR_L;
                            end
                            PH_ADR_L: begin
                                addr_q  <= {hi_q, byte_next};
                                phase_q <= PH_CMD;
                            end
                            PH_CMD: begin
                                cmd_q   <= byte_next;
                                tx_q    <= status_i;
                                re_q    <= byte_next[BYTE_W-1];
                                phase_q <= PH_STAT;
                            end
                            PH_STAT: phase_q <= PH_DATA;
                            PH_DATA: begin
                                if (!cmd_q[BYTE_W-1]) begin
                                    we_q    <= 1'b1;
                                    wdata_q <= byte_next;
                                end
                            end
                            default: phase_q <= PH_ADR_H;
                        endcase
                    end
                end
                if (fall) begin
                    if (phase_q == PH_DATA && bit_q == 3'd0 && cmd_q[BYTE_W-1]) begin
                        miso_q <= rdbuf_q[BYTE_W-1];
                        tx_q   <= {rdbuf_q[BYTE_W-2:0], 1'b0};
                        addr_q <= addr_q + 1'b1;
                        re_q   <= 1'b1;
                    end else if (phase_q == PH_STAT || phase_q == PH_DATA) begin
                        miso_q <= tx_q[BYTE_W-1];
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
                if (cs_end) begin
                    if (phase_q == PH_ADR_L && bit_q == 3'd0) begin
                        done_q     <= 1'b1;
                        done_cmd_q <= hi_q;
                    end else if (multi_end && !idle_code) begin
                        done_q     <= 1'b1;
                        done_cmd_q <= cmd_q;
                    end
                    phase_q <= PH_ADR_H;
                    bit_q   <= '0;
                end
            end
        end
    end

    assign miso_o      = miso_q;
    assign miso_oe_o   = en_i && !csn_s;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wdata_q;
    assign wr_req_o    = we_q;
    assign mem_re_o    = re_q;
    assign done_o      = done_q;
    assign done_cmd_o  = done_cmd_q;
endmodule

// File: rtl/spi_mem_port.sv
// Top level: SPI slave giving a host byte access to a synchronous RAM port
// and a command path to the local processor.
// Assumes sclk_i, csn_i, mosi_i are asynchronous and much slower than clk.
module spi_mem_port
    import spi_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAFE_BASE = 16'h0400,
    parameter int                SAFE_SIZE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [BYTE_W-1:0] status_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              reg_we_i,
    input  logic [CTL_W-1:0]  reg_wdata_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              irq_o
);
    logic [2:0]        pins_s;
    logic              wr_req, allow, done_w;
    logic [BYTE_W-1:0] done_cmd;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mosi_i, csn_i, sclk_i}),
        .q_o   (pins_s)
    );

    spi_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctl_o[CTL_EN]),
        .sclk_s      (pins_s[0]),
        .csn_s       (pins_s[1]),
        .mosi_s      (pins_s[2]),
        .status_i    (status_i),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .wr_req_o    (wr_req),
        .mem_re_o    (mem_re_o),
        .mem_rdata_i (mem_rdata_i),
        .done_o      (done_w),
        .done_cmd_o  (done_cmd)
    );

    spi_safe_gate #(.BASE(SAFE_BASE), .SIZE(SAFE_SIZE)) u_gate (
        .safe_i  (ctl_o[CTL_SAFE]),
        .addr_i  (mem_addr_o),
        .allow_o (allow)
    );

    spi_ctl_regs u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we_i),
        .reg_wdata_i (reg_wdata_i),
        .done_i      (done_w),
        .done_cmd_i  (done_cmd),
        .ctl_o       (ctl_o),
        .cmd_o       (cmd_o),
        .irq_o       (irq_o)
    );

    assign mem_we_o = wr_req && allow;
endmodule

// File: rtl/spi_mem_port_chk.sv
// Property checker for spi_mem_port, attached with bind below.
// Assumes the serial timing stated in the brief.
module spi_mem_port_chk
    import spi_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAFE_BASE = 16'h0400,
    parameter int                SAFE_SIZE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              miso_oe_o,
    input logic              en,
    input logic              safe,
    input logic              flag,
    input logic              reg_we_i,
    input logic              wr_flag_bit,
    input logic              done_w
);
    a_r13_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    a_r3_write_steps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    a_r8_safe_window: assert property (@(posedge clk) disable iff (!rst_n)
        (safe && mem_we_o) |-> ((mem_addr_o - SAFE_BASE) < ADDR_W'(SAFE_SIZE)));

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (!mem_we_o && !mem_re_o && !miso_oe_o));

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && !wr_flag_bit && !done_w) |=> !flag);

    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done_w));
endmodule

bind spi_mem_port spi_mem_port_chk #(.SAFE_BASE(SAFE_BASE), .SAFE_SIZE(SAFE_SIZE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .miso_oe_o   (miso_oe_o),
    .en          (ctl_o[0]),
    .safe        (ctl_o[2]),
    .flag        (ctl_o[3]),
    .reg_we_i    (reg_we_i),
    .wr_flag_bit (reg_wdata_i[3]),
    .done_w      (done_w)
);

// File: tb/spi_mem_port_tb.sv
module spi_mem_port_tb;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso_o, miso_oe_o, mem_we_o, mem_re_o, irq_o;
    logic [7:0]  status = 8'h00;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata, cmd_o;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_wdata = 4'h0;
    logic [3:0]  ctl_o;

    logic [7:0] mem [256];
    int wr_cnt = 0;
    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_b [8];
    logic [7:0] rx_b [8];
    logic oe_all, oe_any;

    always #2 clk = ~clk;

    spi_mem_port u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .status_i(status),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata), .reg_we_i(reg_we),
        .reg_wdata_i(reg_wdata), .ctl_o(ctl_o), .cmd_o(cmd_o), .irq_o(irq_o)
    );

    // Synchronous byte RAM model, aliased on the low address byte.
    always @(posedge clk) begin
        if (mem_we_o) begin
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re_o) mem_rdata <= mem[mem_addr_o[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic spi_xfer(input int nbits);
        oe_all = 1'b1;
        oe_any = 1'b0;
        @(negedge clk);
        csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx_b[i/8][7-(i%8)];
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            rx_b[i/8][7-(i%8)] = miso_o;
            oe_all = oe_all & miso_oe_o;
            oe_any = oe_any | miso_oe_o;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        csn = 1'b1;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5);
        tx_b[0] = b0; tx_b[1] = b1; tx_b[2] = b2;
        tx_b[3] = b3; tx_b[4] = b4; tx_b[5] = b5;
    endtask

    // {address, write command, data0, data1}
    localparam logic [39:0] VEC [4] = '{
        40'h0010_12_3C_C3,
        40'h00FE_45_5A_A5,
        40'h0400_7F_01_80,
        40'h1230_33_FF_00
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(ctl_o == 4'h0, "R12 ctl reset", 32'(ctl_o), 0);
        chk(cmd_o == 8'h00 && irq_o == 1'b0, "R12 cmd/irq reset", {cmd_o, 7'b0, irq_o}, 0);
        chk(miso_oe_o == 1'b0, "R12 oe idle", 32'(miso_oe_o), 0);

        // R11 port disabled: frame ignored
        load(8'h00, 8'h20, 8'h11, 8'h00, 8'h77, 8'h00);
        spi_xfer(40);
        chk(wr_cnt == 0 && !oe_any, "R11 no write/oe while disabled", 32'(wr_cnt), 0);
        chk(cmd_o == 8'h00 && ctl_o[3] == 1'b0, "R11 no cmd while disabled", 32'(cmd_o), 0);

        // Vector table: write then read back, R1 R2 R3 R5 R10 R13
        foreach (VEC[k]) begin
            logic [15:0] a;
            logic [7:0]  c, d0, d1;
            {a, c, d0, d1} = VEC[k];
            reg_wr(4'b0011);
            base = wr_cnt;
            load(a[15:8], a[7:0], c, 8'h00, d0, d1);
            spi_xfer(48);
            chk(wr_cnt == base + 2, "R13 R3 two write strobes", 32'(wr_cnt - base), 2);
            chk(cmd_o == c && ctl_o[3] && irq_o, "R5 R10 write cmd update", {ctl_o[3], irq_o, cmd_o}, {2'b11, c});
            chk(!miso_oe_o && oe_all, "R12 oe follows chip select", {oe_all, miso_oe_o}, 2);
            reg_wr(4'b0011);
            status = ~d0;
            load(a[15:8], a[7:0], {1'b1, c[6:0]}, 8'h00, 8'h00, 8'h00);
            spi_xfer(48);
            chk(rx_b[3] == ~d0, "R2 status byte", 32'(rx_b[3]), 32'(~d0));
            chk(rx_b[4] == d0, "R1 R2 first read byte", 32'(rx_b[4]), 32'(d0));
            chk(rx_b[5] == d1, "R3 incremented read byte", 32'(rx_b[5]), 32'(d1));
            chk(cmd_o == {1'b1, c[6:0]}, "R5 read cmd update", 32'(cmd_o), 32'({1'b1, c[6:0]}));
        end

        // R4 single-byte frames, any value
        reg_wr(4'b0011);
        tx_b[0] = 8'h80; spi_xfer(8);
        chk(cmd_o == 8'h80 && ctl_o[3], "R4 single 0x80", 32'(cmd_o), 32'h80);
        reg_wr(4'b0011);
        tx_b[0] = 8'h00; spi_xfer(8);
        chk(cmd_o == 8'h00 && ctl_o[3], "R4 single 0x00", {ctl_o[3], cmd_o}, 32'h100);
        reg_wr(4'b0011);
        tx_b[0] = 8'h5E; spi_xfer(8);
        reg_wr(4'b0011);

        // R6 idle command codes
        base = wr_cnt;
        load(8'h00, 8'h40, 8'h00, 8'h00, 8'h99, 8'h00);
        spi_xfer(40);
        chk(cmd_o == 8'h5E && !ctl_o[3], "R6 write idle code", {ctl_o[3], cmd_o}, 32'h5E);
        chk(wr_cnt == base + 1, "R6 write idle data stored", 32'(wr_cnt - base), 1);
        load(8'h00, 8'h40, 8'h80, 8'h00, 8'h00, 8'h00);
        spi_xfer(40);
        chk(cmd_o == 8'h5E && !ctl_o[3], "R6 read idle code", {ctl_o[3], cmd_o}, 32'h5E);
        chk(rx_b[4] == 8'h99, "R6 read idle data", 32'(rx_b[4]), 32'h99);

        // R7 two-byte and partial frames
        load(8'h00, 8'h50, 8'h00, 8'h00, 8'h00, 8'h00);
        spi_xfer(16);
        chk(cmd_o == 8'h5E && !ctl_o[3], "R7 two-byte frame", {ctl_o[3], cmd_o}, 32'h5E);
        base = wr_cnt;
        load(8'h00, 8'h50, 8'h22, 8'h00, 8'h44, 8'hF0);
        spi_xfer(44);
        chk(wr_cnt == base + 1, "R7 partial byte not written", 32'(wr_cnt - base), 1);
        chk(cmd_o == 8'h5E && !ctl_o[3], "R7 partial frame", {ctl_o[3], cmd_o}, 32'h5E);

        // R8 safe mode window
        reg_wr(4'b0111);
        base = wr_cnt;
        load(8'h00, 8'h60, 8'h23, 8'h00, 8'h11, 8'h00);
        spi_xfer(40);
        chk(wr_cnt == base, "R8 outside window blocked", 32'(wr_cnt - base), 0);
        chk(cmd_o == 8'h23 && ctl_o[3], "R8 cmd still updated", 32'(cmd_o), 32'h23);
        base = wr_cnt;
        load(8'h04, 8'h0F, 8'h24, 8'h00, 8'h66, 8'h67);
        spi_xfer(48);
        chk(wr_cnt == base + 1, "R8 window top edge", 32'(wr_cnt - base), 1);
        base = wr_cnt;
        load(8'h03, 8'hFF, 8'h25, 8'h00, 8'h68, 8'h00);
        spi_xfer(40);
        chk(wr_cnt == base, "R8 below window blocked", 32'(wr_cnt - base), 0);

        // R9 flag write semantics, R10 gating
        reg_wr(4'b1001);
        chk(ctl_o == 4'b1001 && !irq_o, "R10 irq gated by enable", {irq_o, ctl_o}, 32'h9);
        reg_wr(4'b1011);
        chk(ctl_o[3] && irq_o, "R9 writing 1 keeps flag", {irq_o, ctl_o}, 32'h1B);
        reg_wr(4'b0011);
        chk(!ctl_o[3] && !irq_o, "R9 writing 0 clears flag", {irq_o, ctl_o}, 32'h3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule